// File: doc/BRIEF.md
# Multiplexed external bus sequencer

This block runs the external memory bus of a small 8-bit controller core that has no internal program store. Time is divided into six-period slots, one clock per oscillator period. With no data request pending, every slot is an instruction fetch. The fetch puts the low program-counter byte on the shared port while an address latch strobe pulses. It then floats the port and pulls the program-store read strobe low. The byte on the port is captured during the last low period of that strobe. The high address byte stays on a second port for the whole slot.

A data-memory request from the core replaces two fetch slots with one twelve-period access. The first slot still latches an address, now the data address, and the second slot has no latch pulse. Neither slot has a program-store pulse. Instead, a read or write strobe goes low three periods after the latch strobe falls and stays low for six periods. A read captures the port in the last low period. A write drives the data byte onto the shared port from the strobe's falling edge until one period after it rises. An access with an 8-bit address shows the core's port register value on the second port instead of an address byte.

The core holds its request until it sees the grant pulse. The fetched byte comes back with a one-period valid pulse, and read data comes back with a one-period done pulse.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high (synchronous reset), `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `p0_out`=all ones and `p2_out`=all ones.
- R2: With no data request, slots repeat every 6 periods. In slot phases 0..5, `ale` is high in phases 0-1 (2 periods) and `psen_n` is low in phases 3-5 (3 periods).
- R3: In a fetch slot, `p0_oe`=1 and `p0_out`=program counter bits [7:0] in phases 0-2, and `p0_oe`=0 in phases 3-5. `p2_out`=program counter bits [15:8] for all six periods. The program counter is sampled at the slot boundary.
- R4: `p0_in` is sampled in fetch phase 5. That value appears on `instr` with `instr_vld`=1 for exactly the next period (phase 0 of the following slot). `instr_vld` is 0 otherwise.
- R5: A raised `dreq` is taken only at a slot boundary, so a fetch slot already under way completes with its `psen_n` pulse. `dgnt` is 1 in the first period of the access. The access lasts 12 periods, with `ale` high in its periods 0-1 only and `psen_n` high throughout.
- R6: In access period 5 through period 10, `rd_n` is low for a read (`dwr`=0) or `wr_n` is low for a write (`dwr`=1). The strobe therefore falls 3 periods after `ale` falls and stays low for 6 periods. The two strobes are never low together.
- R7: For a read, `p0_in` is sampled in access period 10. `rdata` carries that value and `dack`=1 in access period 11. `dack` is also 1 in period 11 of a write.
- R8: In access periods 0-2, `p0_oe`=1 and `p0_out`=`daddr`[7:0]. For a read, `p0_oe`=0 in periods 3-11. For a write, `p0_oe`=0 in periods 3-4, and `p0_oe`=1 with `p0_out`=`dwdata` in periods 5-11.
- R9: Throughout an access, `p2_out`=`daddr`[15:8] when `dwide`=1 and `p2_out`=`p2_reg` when `dwide`=0.
- R10: The slot right after an access is a fetch, with `ale` high and `p0_out`/`p2_out` showing the program counter in its phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | ADDR_W | Program counter for the next fetch |
| dreq | input | 1 | Data-memory access request, held until granted |
| dwr | input | 1 | 1 = write, 0 = read |
| dwide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| daddr | input | ADDR_W | Data address |
| dwdata | input | DATA_W | Write data |
| p2_reg | input | DATA_W | Port register value shown on the high port for 8-bit accesses |
| dgnt | output | 1 | Pulse: request taken, access begins |
| dack | output | 1 | Pulse: access complete, read data valid |
| rdata | output | DATA_W | Data read from external memory |
| instr | output | DATA_W | Fetched program byte |
| instr_vld | output | 1 | Pulse: `instr` valid |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | DATA_W | Shared address/data port, output value |
| p0_oe | output | 1 | Shared port output enable |
| p0_in | input | DATA_W | Shared port, input value |
| p2_out | output | DATA_W | High address / port register output |

## Verification
The bench uses the default `DATA_W`=8, which makes `ADDR_W`=16. With these values every address splits into exactly one latched low byte and one high byte, and all-zero and all-ones program counters and data bytes can be checked at the port edges. Each data access is checked period by period across its full twelve periods: wide and narrow, read and write. A request raised in the middle of a fetch slot is also driven, to show that the grant waits for the slot boundary.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_FETCH = 2'd1,
    SLOT_DA    = 2'd2,
    SLOT_DB    = 2'd3
  } slot_e;

  localparam int SLOT_LEN = 6;
  localparam int PH_W     = $clog2(SLOT_LEN);

  localparam logic [PH_W-1:0] PH_LAST      = PH_W'(SLOT_LEN - 1);
  localparam logic [PH_W-1:0] PH_ALE_LAST  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ADDR_LAST = PH_W'(2);
  localparam logic [PH_W-1:0] PH_PSEN_FST  = PH_W'(3);
  localparam logic [PH_W-1:0] PH_STB_A_FST = PH_W'(5);
  localparam logic [PH_W-1:0] PH_STB_B_LST = PH_W'(4);

  localparam int STB_LEN = SLOT_LEN - 5 + 4 + 1;
endpackage

// File: rtl/ebs_slot_ctrl.sv
module ebs_slot_ctrl
  import ebs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq,
  input  logic              dwr,
  input  logic              dwide,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [DATA_W-1:0] dwdata,
  output logic [PH_W-1:0]   ph,
  output slot_e             kind,
  output logic              cur_wr,
  output logic [PH_W-1:0]   nxt_ph,
  output slot_e             nxt_kind,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              nxt_wr,
  output logic              nxt_wide,
  output logic [DATA_W-1:0] nxt_wdata,
  output logic              dgnt
);
  logic [ADDR_W-1:0] addr_q;
  logic              wide_q;
  logic [DATA_W-1:0] wdata_q;
  logic              boundary;

  assign boundary = (ph == PH_LAST) && (kind != SLOT_DA);

  always_comb begin
    nxt_ph    = (ph == PH_LAST) ? '0 : ph + PH_W'(1);
    nxt_kind  = kind;
    nxt_addr  = addr_q;
    nxt_wr    = cur_wr;
    nxt_wide  = wide_q;
    nxt_wdata = wdata_q;
    if (ph == PH_LAST) begin
      if (kind == SLOT_DA) begin
        nxt_kind = SLOT_DB;
      end else begin
        nxt_kind  = dreq ? SLOT_DA : SLOT_FETCH;
        nxt_addr  = dreq ? daddr : pc;
        nxt_wr    = dreq & dwr;
        nxt_wide  = dreq & dwide;
        nxt_wdata = dwdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_LAST;
      kind    <= SLOT_NONE;
      addr_q  <= '0;
      cur_wr  <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
      dgnt    <= 1'b0;
    end else begin
      ph      <= nxt_ph;
      kind    <= nxt_kind;
      addr_q  <= nxt_addr;
      cur_wr  <= nxt_wr;
      wide_q  <= nxt_wide;
      wdata_q <= nxt_wdata;
      dgnt    <= boundary & dreq;
    end
  end

  // R5
  da_then_db_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == SLOT_DA && ph == PH_LAST) |=> (kind == SLOT_DB && ph == '0));

  // R5
  gnt_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    dgnt |-> (kind == SLOT_DA && ph == '0));
endmodule

// File: rtl/ebs_bus_drive.sv
module ebs_bus_drive
  import ebs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   nxt_ph,
  input  slot_e             nxt_kind,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_wr,
  input  logic              nxt_wide,
  input  logic [DATA_W-1:0] nxt_wdata,
  input  logic [DATA_W-1:0] p2_reg,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [DATA_W-1:0] p2_out
);
  logic is_fetch, is_da, is_db, stb, addr_ph, wdat_ph;
  logic ale_d, psen_d, rd_d, wr_d, oe_d;
  logic [DATA_W-1:0] p0_d, p2_d, lo_b, hi_b;

  assign lo_b = nxt_addr[DATA_W-1:0];
  assign hi_b = nxt_addr[ADDR_W-1:DATA_W];

  always_comb begin
    is_fetch = (nxt_kind == SLOT_FETCH);
    is_da    = (nxt_kind == SLOT_DA);
    is_db    = (nxt_kind == SLOT_DB);
    ale_d    = (is_fetch || is_da) && (nxt_ph <= PH_ALE_LAST);
    psen_d   = !(is_fetch && (nxt_ph >= PH_PSEN_FST));
    stb      = (is_da && (nxt_ph >= PH_STB_A_FST)) ||
               (is_db && (nxt_ph <= PH_STB_B_LST));
    rd_d     = !(stb && !nxt_wr);
    wr_d     = !(stb && nxt_wr);
    addr_ph  = (is_fetch || is_da) && (nxt_ph <= PH_ADDR_LAST);
    wdat_ph  = nxt_wr && ((is_da && (nxt_ph >= PH_STB_A_FST)) || is_db);
    oe_d     = addr_ph || wdat_ph;
    p0_d     = addr_ph ? lo_b : (wdat_ph ? nxt_wdata : '1);
    if (is_fetch)             p2_d = hi_b;
    else if (is_da || is_db)  p2_d = nxt_wide ? hi_b : p2_reg;
    else                      p2_d = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      p0_out <= '1;
      p0_oe  <= 1'b0;
      p2_out <= '1;
    end else begin
      ale    <= ale_d;
      psen_n <= psen_d;
      rd_n   <= rd_d;
      wr_n   <= wr_d;
      p0_out <= p0_d;
      p0_oe  <= oe_d;
      p2_out <= p2_d;
    end
  end

  logic [3:0] lo_cnt;
  always_ff @(posedge clk) begin
    if (rst)                lo_cnt <= '0;
    else if (!rd_n || !wr_n) lo_cnt <= lo_cnt + 4'd1;
    else                    lo_cnt <= '0;
  end

  // R6
  stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R6
  stb_len_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_n && wr_n) && !$past(rd_n && wr_n)) |-> (lo_cnt == 4'(STB_LEN)));

  // R6
  stb_delay_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) || $fell(wr_n)) |-> (!$past(ale, 3) && $past(ale, 4)));

  // R2
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ($past(ale, 1) && $past(ale, 2) && !$past(ale, 3)));

  // R2
  psen_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(psen_n) |-> ($past(!psen_n, 1) && $past(!psen_n, 2) &&
                       $past(!psen_n, 3) && $past(psen_n, 4)));

  // R5
  ale_psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  // R8
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe);
endmodule

// File: rtl/ebs_capture.sv
module ebs_capture
  import ebs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PH_W-1:0]   ph,
  input  slot_e             kind,
  input  logic              cur_wr,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] instr,
  output logic              instr_vld,
  output logic [DATA_W-1:0] rdata,
  output logic              dack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      instr     <= '0;
      instr_vld <= 1'b0;
      rdata     <= '0;
      dack      <= 1'b0;
    end else begin
      instr_vld <= 1'b0;
      dack      <= 1'b0;
      if (kind == SLOT_FETCH && ph == PH_LAST) begin
        instr     <= p0_in;
        instr_vld <= 1'b1;
      end
      if (kind == SLOT_DB && ph == PH_STB_B_LST) begin
        dack <= 1'b1;
        if (!cur_wr) rdata <= p0_in;
      end
    end
  end

  // R4
  vld_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(instr_vld && dack));

  // R4
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    instr_vld |=> !instr_vld);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc,
  input  logic              dreq,
  input  logic              dwr,
  input  logic              dwide,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [DATA_W-1:0] dwdata,
  input  logic [DATA_W-1:0] p2_reg,
  output logic              dgnt,
  output logic              dack,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] instr,
  output logic              instr_vld,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  input  logic [DATA_W-1:0] p0_in,
  output logic [DATA_W-1:0] p2_out
);
  logic [PH_W-1:0]   ph, nxt_ph;
  slot_e             kind, nxt_kind;
  logic              cur_wr, nxt_wr, nxt_wide;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_wdata;

  ebs_slot_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .pc(pc), .dreq(dreq), .dwr(dwr), .dwide(dwide),
    .daddr(daddr), .dwdata(dwdata), .ph(ph), .kind(kind), .cur_wr(cur_wr),
    .nxt_ph(nxt_ph), .nxt_kind(nxt_kind), .nxt_addr(nxt_addr),
    .nxt_wr(nxt_wr), .nxt_wide(nxt_wide), .nxt_wdata(nxt_wdata), .dgnt(dgnt)
  );

  ebs_bus_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) drive_i (
    .clk(clk), .rst(rst), .nxt_ph(nxt_ph), .nxt_kind(nxt_kind),
    .nxt_addr(nxt_addr), .nxt_wr(nxt_wr), .nxt_wide(nxt_wide),
    .nxt_wdata(nxt_wdata), .p2_reg(p2_reg), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  ebs_capture #(.DATA_W(DATA_W)) cap_i (
    .clk(clk), .rst(rst), .ph(ph), .kind(kind), .cur_wr(cur_wr),
    .p0_in(p0_in), .instr(instr), .instr_vld(instr_vld),
    .rdata(rdata), .dack(dack)
  );

  // R7
  dack_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    dack |-> (rd_n && wr_n && $past(!rd_n || !wr_n)));
endmodule

// File: tb/ext_bus_seq_tb_top.sv
`timescale 1ns/1ps
module ext_bus_seq_tb_top;
  localparam int DW = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] pc = '0;
  logic dreq = 1'b0, dwr = 1'b0, dwide = 1'b0;
  logic [AW-1:0] daddr = '0;
  logic [DW-1:0] dwdata = '0, p2_reg = '0, p0_in = '0;
  logic dgnt, dack, instr_vld, ale, psen_n, rd_n, wr_n, p0_oe;
  logic [DW-1:0] rdata, instr, p0_out, p2_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ext_bus_seq #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .pc(pc), .dreq(dreq), .dwr(dwr), .dwide(dwide),
    .daddr(daddr), .dwdata(dwdata), .p2_reg(p2_reg), .dgnt(dgnt),
    .dack(dack), .rdata(rdata), .instr(instr), .instr_vld(instr_vld),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out),
    .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out)
  );

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ale", 32'(ale), 32'(0));
    chk("R1 psen_n", 32'(psen_n), 32'(1));
    chk("R1 rd_n", 32'(rd_n), 32'(1));
    chk("R1 wr_n", 32'(wr_n), 32'(1));
    chk("R1 p0_oe", 32'(p0_oe), 32'(0));
    chk("R1 p0_out", 32'(p0_out), 32'hFF);
    chk("R1 p2_out", 32'(p2_out), 32'hFF);
    rst = 1'b0;
  endtask

  task automatic sync_slot();
    logic prev;
    do begin
      prev = ale;
      @(negedge clk);
    end while (!(ale && !prev));
  endtask

  task automatic t_fetch(input logic [AW-1:0] pcv, input logic [DW-1:0] ib);
    pc = pcv;
    sync_slot();
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      chk($sformatf("R2 ale ph%0d", i), 32'(ale), 32'(i <= 1));
      chk($sformatf("R2 psen_n ph%0d", i), 32'(psen_n), 32'(i < 3));
      chk($sformatf("R3 p0_oe ph%0d", i), 32'(p0_oe), 32'(i <= 2));
      if (i <= 2) chk($sformatf("R3 p0_out ph%0d", i), 32'(p0_out), 32'(pcv[7:0]));
      chk($sformatf("R3 p2_out ph%0d", i), 32'(p2_out), 32'(pcv[15:8]));
      if (i == 3) begin
        chk("R4 instr_vld idle", 32'(instr_vld), 32'(0));
        p0_in = ib;
      end
    end
    @(negedge clk);
    chk("R4 instr_vld", 32'(instr_vld), 32'(1));
    chk("R4 instr", 32'(instr), 32'(ib));
  endtask

  task automatic t_data(input logic wr, input logic wide, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                        input logic [DW-1:0] p2v);
    logic stb;
    p2_reg = p2v; daddr = a; dwr = wr; dwide = wide; dwdata = wd;
    dreq = 1'b1;
    do @(negedge clk); while (!dgnt);
    dreq = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      stb = (i >= 5) && (i <= 10);
      chk($sformatf("R5 ale p%0d", i), 32'(ale), 32'(i <= 1));
      chk($sformatf("R5 psen_n p%0d", i), 32'(psen_n), 32'(1));
      chk($sformatf("R6 rd_n p%0d", i), 32'(rd_n), 32'(!(stb && !wr)));
      chk($sformatf("R6 wr_n p%0d", i), 32'(wr_n), 32'(!(stb && wr)));
      chk($sformatf("R8 p0_oe p%0d", i), 32'(p0_oe), 32'((i <= 2) || (wr && i >= 5)));
      if (i <= 2) chk($sformatf("R8 addr p%0d", i), 32'(p0_out), 32'(a[7:0]));
      if (wr && i >= 5) chk($sformatf("R8 wdata p%0d", i), 32'(p0_out), 32'(wd));
      chk($sformatf("R9 p2_out p%0d", i), 32'(p2_out), 32'(wide ? a[15:8] : p2v));
      chk($sformatf("R7 dack p%0d", i), 32'(dack), 32'(i == 11));
      if (i == 5) p0_in = wr ? ~rv : rv;
      if (i == 11 && !wr) chk("R7 rdata", 32'(rdata), 32'(rv));
    end
    @(negedge clk);
    chk("R10 ale", 32'(ale), 32'(1));
    chk("R10 p0_out", 32'(p0_out), 32'(pc[7:0]));
    chk("R10 p2_out", 32'(p2_out), 32'(pc[15:8]));
  endtask

  task automatic t_mid_request();
    sync_slot();
    @(negedge clk);
    daddr = 16'h0011; dwr = 1'b0; dwide = 1'b0; dreq = 1'b1;
    for (int i = 2; i < 6; i++) begin
      @(negedge clk);
      chk($sformatf("R5 mid psen_n ph%0d", i), 32'(psen_n), 32'(i < 3));
      chk($sformatf("R5 mid dgnt ph%0d", i), 32'(dgnt), 32'(0));
    end
    @(negedge clk);
    chk("R5 mid dgnt", 32'(dgnt), 32'(1));
    dreq = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1-R10 got=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fetch(16'h1234, 8'hAB);
    t_fetch(16'hFFFF, 8'h00);
    t_fetch(16'h0000, 8'hFF);
    t_fetch(16'h5A3C, 8'h69);
    t_data(1'b0, 1'b1, 16'hBEEF, 8'h00, 8'h5A, 8'h77);
    t_data(1'b0, 1'b0, 16'h0042, 8'h00, 8'hC3, 8'h3C);
    t_data(1'b1, 1'b1, 16'h8001, 8'h96, 8'h00, 8'h11);
    t_data(1'b1, 1'b0, 16'h00FE, 8'h0F, 8'h00, 8'hE4);
    t_mid_request();
    t_fetch(16'h7E81, 8'h42);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule